// File: doc/BRIEF.md
# Virtual Address Translation Unit with Permission Checks

The unit maps 14-bit virtual addresses onto 12-bit physical addresses, with 64-byte pages. Each request carries an address and an access kind. The access kind is read, write or instruction fetch. Recent page table entries are held in a 16-entry, 4-way set-associative translation cache. A request that finds its page there is answered on the next cycle.

On a lookup miss, the unit reads the page table entry from a memory port. The entry's address is the page table base input plus the virtual page number. The unit then stores the entry in the cache and answers. The answer is one of three:

- a physical address;
- a page fault, when the entry is not valid;
- a protection fault, when the entry does not grant the requested kind of access.

A flush input empties the cache in one cycle. Software uses it after it changes the page table base or edits an entry.

Top module: `mmu_xlate`

## Requirements
- R1: The low 6 bits of the virtual address (the page offset) pass unchanged into the low 6 bits of the physical address. The upper 6 bits of the physical address are the physical page number.
- R2: The cache has 4 sets of 4 ways. The set is chosen by virtual page number bits [1:0], and the tag is virtual page number bits [7:2]. A hit answers in the cycle after acceptance (respValid high) without raising memReqValid.
- R3: On a miss, memReqValid rises in the cycle after acceptance, with memAddr = ptBase + virtual page number (12-bit sum). memReqValid and memAddr are held, and reqReady stays low, until memRspValid. The answer appears in the cycle after memRspValid.
- R4: Page table entry format:
  - bit 0: valid
  - bit 1: read allowed
  - bit 2: write allowed
  - bit 3: execute allowed
  - bits [9:4]: physical page number
- R5: A fetched entry with valid = 0 gives respPageFault = 1 and respPaddr = 0. Nothing is stored, so the next access to that page fetches from memory again.
- R6: reqKind encodings are 0 = read, 1 = write, 2 = fetch and 3 = reserved. Read needs the read bit, write needs the write bit, and fetch needs the execute bit. Reserved never passes. A failed check gives respProtFault = 1 and respPaddr = 0, on hits as well as on fetched entries.
- R7: A valid fetched entry is stored even when its permission check fails, so a later access to that page hits.
- R8: A fill goes to the lowest-numbered invalid way of its set. If the set is full, the fill goes to a per-set round-robin pointer, which then advances. So the fifth distinct page filled into one set evicts the first.
- R9: A flush pulse invalidates every entry in one cycle. A request accepted in the next cycle misses.
- R10: If flush is raised while a fetch from memory is outstanding, the answer is still returned, but the entry is not stored.
- R11: respPageFault and respProtFault are never high together.
- R12: After reset, reqReady = 1, respValid = 0, memReqValid = 0, and the cache is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Unit can accept a request |
| reqVaddr | input | 14 | Virtual address |
| reqKind | input | 2 | Access kind (0 read, 1 write, 2 fetch, 3 reserved) |
| ptBase | input | 12 | Page table base address |
| flush | input | 1 | Invalidate all cached entries |
| respValid | output | 1 | Answer present for one cycle |
| respPaddr | output | 12 | Physical address, 0 on any fault |
| respPageFault | output | 1 | Entry not valid |
| respProtFault | output | 1 | Access kind not permitted |
| memReqValid | output | 1 | Page table entry read outstanding |
| memAddr | output | 12 | Page table entry address |
| memRspValid | input | 1 | Page table entry data present |
| memRspData | input | 10 | Page table entry |

## Verification
A corrupted valid bit or tag in the cache shows up at the ports on the very next access to that page. Such an access either raises memReqValid when it should not, or answers when it should have fetched the entry from memory. A wrong replacement pointer only appears after one set has been filled past four pages, so the bench first fills a set and then probes which page was evicted. A lost flush, or a fill that slips through during a flush, is visible one access later as a missing memory fetch.

// File: rtl/mmu_pkg.sv
package mmu_pkg;
  localparam int VA_W  = 14;
  localparam int PA_W  = 12;
  localparam int OFF_W = 6;
  localparam int WAYS  = 4;
  localparam int SETS  = 4;

  localparam int VPN_W = VA_W - OFF_W;
  localparam int PPN_W = PA_W - OFF_W;
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = VPN_W - IDX_W;
  localparam int WAY_W = $clog2(WAYS);
  localparam int PTE_W = PPN_W + 4;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_e;

  // strobes from control to datapath
  typedef struct packed {
    logic latchReq;
    logic respHit;
    logic respWalk;
    logic fillEn;
    logic flushAll;
  } ctl_t;

  function automatic logic permOk(acc_e kind, logic rd, logic wr, logic ex);
    case (kind)
      ACC_READ:  permOk = rd;
      ACC_WRITE: permOk = wr;
      ACC_FETCH: permOk = ex;
      default:   permOk = 1'b0;
    endcase
  endfunction
endpackage

// File: rtl/mmu_ctrl.sv
module mmu_ctrl
  import mmu_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic reqValid,
  input  logic lookupHit,
  input  logic memRspValid,
  input  logic pteValid,
  input  logic flush,
  output logic reqReady,
  output logic memReqValid,
  output ctl_t ctl
);
  typedef enum logic {ST_IDLE, ST_WALK} state_e;
  state_e state;
  logic dropFill;
  logic accept;

  always_comb begin
    reqReady     = (state == ST_IDLE);
    memReqValid  = (state == ST_WALK);
    accept       = reqValid && reqReady;
    ctl.latchReq = accept && !lookupHit;
    ctl.respHit  = accept && lookupHit;
    ctl.respWalk = (state == ST_WALK) && memRspValid;
    ctl.fillEn   = ctl.respWalk && pteValid && !dropFill && !flush;
    ctl.flushAll = flush;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      dropFill <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (ctl.latchReq) state <= ST_WALK;
        ST_WALK: if (memRspValid) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
      if (ctl.latchReq) dropFill <= 1'b0;
      else if (state == ST_WALK && flush) dropFill <= 1'b1;
    end
  end
endmodule

// File: rtl/mmu_dpath.sv
module mmu_dpath
  import mmu_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic [VA_W-1:0]  reqVaddr,
  input  logic [1:0]       reqKind,
  input  logic [PA_W-1:0]  ptBase,
  input  logic [PTE_W-1:0] memRspData,
  input  ctl_t             ctl,
  output logic             lookupHit,
  output logic             pteValid,
  output logic [PA_W-1:0]  memAddr,
  output logic             respValid,
  output logic [PA_W-1:0]  respPaddr,
  output logic             respPageFault,
  output logic             respProtFault
);
  logic [TAG_W-1:0] tagArr  [SETS][WAYS];
  logic [PPN_W-1:0] ppnArr  [SETS][WAYS];
  logic [2:0]       permArr [SETS][WAYS];
  logic [WAYS-1:0]  vldArr  [SETS];
  logic [WAY_W-1:0] rrPtr   [SETS];

  // lookup on the incoming request
  logic [VPN_W-1:0] reqVpn;
  logic [IDX_W-1:0] reqSet;
  logic [TAG_W-1:0] reqTag;
  logic [WAYS-1:0]  hitVec;
  logic [PPN_W-1:0] hitPpn;
  logic [2:0]       hitPerm;

  assign reqVpn = reqVaddr[VA_W-1:OFF_W];
  assign reqSet = reqVpn[IDX_W-1:0];
  assign reqTag = reqVpn[VPN_W-1:IDX_W];

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign hitVec[w] = vldArr[reqSet][w] && (tagArr[reqSet][w] == reqTag);
  end

  assign lookupHit = |hitVec;

  always_comb begin
    hitPpn  = '0;
    hitPerm = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hitVec[w]) begin
        hitPpn  = ppnArr[reqSet][w];
        hitPerm = permArr[reqSet][w];
      end
    end
  end

  // request held during a table walk
  logic [VA_W-1:0]  curVaddr;
  acc_e             curKind;
  logic [VPN_W-1:0] curVpn;
  logic [IDX_W-1:0] curSet;
  logic [TAG_W-1:0] curTag;

  assign curVpn  = curVaddr[VA_W-1:OFF_W];
  assign curSet  = curVpn[IDX_W-1:0];
  assign curTag  = curVpn[VPN_W-1:IDX_W];
  assign memAddr = ptBase + {{(PA_W-VPN_W){1'b0}}, curVpn};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curVaddr <= '0;
      curKind  <= ACC_READ;
    end else if (ctl.latchReq) begin
      curVaddr <= reqVaddr;
      curKind  <= acc_e'(reqKind);
    end
  end

  // page table entry fields
  logic [PPN_W-1:0] ptePpn;
  logic             pteRd, pteWr, pteEx;
  assign pteValid = memRspData[0];
  assign pteRd    = memRspData[1];
  assign pteWr    = memRspData[2];
  assign pteEx    = memRspData[3];
  assign ptePpn   = memRspData[PTE_W-1:4];

  // victim way: lowest free way, else round-robin pointer
  logic [WAY_W-1:0] victim;
  logic             hasFree;

  always_comb begin
    victim  = rrPtr[curSet];
    hasFree = 1'b0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!vldArr[curSet][w]) begin
        victim  = WAY_W'(w);
        hasFree = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        vldArr[s] <= '0;
        rrPtr[s]  <= '0;
      end
    end else if (ctl.flushAll) begin
      for (int s = 0; s < SETS; s++) vldArr[s] <= '0;
    end else if (ctl.fillEn) begin
      vldArr[curSet][victim] <= 1'b1;
      if (!hasFree) rrPtr[curSet] <= victim + WAY_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (ctl.fillEn) begin
      tagArr[curSet][victim]  <= curTag;
      ppnArr[curSet][victim]  <= ptePpn;
      permArr[curSet][victim] <= {pteEx, pteWr, pteRd};
    end
  end

  // response register
  logic hitOk, walkOk;
  assign hitOk  = permOk(acc_e'(reqKind), hitPerm[0], hitPerm[1], hitPerm[2]);
  assign walkOk = permOk(curKind, pteRd, pteWr, pteEx);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid     <= 1'b0;
      respPaddr     <= '0;
      respPageFault <= 1'b0;
      respProtFault <= 1'b0;
    end else begin
      respValid     <= ctl.respHit || ctl.respWalk;
      respPaddr     <= '0;
      respPageFault <= 1'b0;
      respProtFault <= 1'b0;
      if (ctl.respHit) begin
        respProtFault <= !hitOk;
        if (hitOk) respPaddr <= {hitPpn, reqVaddr[OFF_W-1:0]};
      end else if (ctl.respWalk) begin
        if (!pteValid) begin
          respPageFault <= 1'b1;
        end else begin
          respProtFault <= !walkOk;
          if (walkOk) respPaddr <= {ptePpn, curVaddr[OFF_W-1:0]};
        end
      end
    end
  end
endmodule

// File: rtl/mmu_xlate.sv
module mmu_xlate
  import mmu_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [VA_W-1:0]  reqVaddr,
  input  logic [1:0]       reqKind,
  input  logic [PA_W-1:0]  ptBase,
  input  logic             flush,
  output logic             respValid,
  output logic [PA_W-1:0]  respPaddr,
  output logic             respPageFault,
  output logic             respProtFault,
  output logic             memReqValid,
  output logic [PA_W-1:0]  memAddr,
  input  logic             memRspValid,
  input  logic [PTE_W-1:0] memRspData
);
  ctl_t ctl;
  logic lookupHit;
  logic pteValid;

  mmu_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .lookupHit   (lookupHit),
    .memRspValid (memRspValid),
    .pteValid    (pteValid),
    .flush       (flush),
    .reqReady    (reqReady),
    .memReqValid (memReqValid),
    .ctl         (ctl)
  );

  mmu_dpath u_dpath (
    .clk           (clk),
    .rstN          (rstN),
    .reqVaddr      (reqVaddr),
    .reqKind       (reqKind),
    .ptBase        (ptBase),
    .memRspData    (memRspData),
    .ctl           (ctl),
    .lookupHit     (lookupHit),
    .pteValid      (pteValid),
    .memAddr       (memAddr),
    .respValid     (respValid),
    .respPaddr     (respPaddr),
    .respPageFault (respPageFault),
    .respProtFault (respProtFault)
  );
endmodule

// File: rtl/mmu_xlate_chk.sv
module mmu_xlate_chk
  import mmu_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic             reqReady,
  input logic [VA_W-1:0]  reqVaddr,
  input logic [1:0]       reqKind,
  input logic [PA_W-1:0]  ptBase,
  input logic             flush,
  input logic             respValid,
  input logic [PA_W-1:0]  respPaddr,
  input logic             respPageFault,
  input logic             respProtFault,
  input logic             memReqValid,
  input logic [PA_W-1:0]  memAddr,
  input logic             memRspValid,
  input logic [PTE_W-1:0] memRspData
);
  logic [OFF_W-1:0] lastOff;

  always_ff @(posedge clk) begin
    if (!rstN) lastOff <= '0;
    else if (reqValid && reqReady) lastOff <= reqVaddr[OFF_W-1:0];
  end

  p_offset_kept_r1: assert property (@(posedge clk) disable iff (!rstN)
    respValid && !respPageFault && !respProtFault |-> respPaddr[OFF_W-1:0] == lastOff);

  p_accept_progress_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> respValid || memReqValid);

  p_walk_held_r3: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid && !memRspValid |=> memReqValid && $stable(memAddr));

  p_walk_stalls_r3: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> !reqReady);

  p_pagefault_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    respPageFault |-> respValid && respPaddr == '0);

  p_protfault_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    respProtFault |-> respValid && respPaddr == '0);

  p_flush_misses_r9: assert property (@(posedge clk) disable iff (!rstN)
    $past(flush) && reqValid && reqReady |=> memReqValid);

  p_fault_exclusive_r11: assert property (@(posedge clk) disable iff (!rstN)
    !(respPageFault && respProtFault));
endmodule

bind mmu_xlate mmu_xlate_chk u_chk (.*);

// File: tb/sim_mmu_xlate.sv
module sim_mmu_xlate;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [13:0] reqVaddr = '0;
  logic [1:0]  reqKind = '0;
  logic [11:0] ptBase = 12'h100;
  logic        flush = 1'b0;
  logic        respValid;
  logic [11:0] respPaddr;
  logic        respPageFault;
  logic        respProtFault;
  logic        memReqValid;
  logic [11:0] memAddr;
  logic        memRspValid = 1'b0;
  logic [9:0]  memRspData = '0;

  int nChecks = 0;
  int nFail = 0;
  logic [9:0] pt [256];

  always #5 clk = ~clk;

  mmu_xlate u0 (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one access; expectation comes from the bench page table (R4, R5, R6, R1)
  task automatic access(input logic [13:0] va, input logic [1:0] kind,
                        input bit expWalk, input bit flushMid, input string req);
    logic [7:0] vpn;
    logic [9:0] pte;
    bit ok, expPf, expPrf;
    logic [11:0] expPa;
    vpn = va[13:6];
    pte = pt[vpn];
    case (kind)
      2'd0: ok = pte[1];
      2'd1: ok = pte[2];
      2'd2: ok = pte[3];
      default: ok = 1'b0;
    endcase
    expPf  = !pte[0];
    expPrf = pte[0] && !ok;
    expPa  = (pte[0] && ok) ? {pte[9:4], va[5:0]} : 12'h000;

    @(negedge clk);
    chk(reqReady == 1'b1, req, "ready before request", int'(reqReady), 1);
    reqValid = 1'b1; reqVaddr = va; reqKind = kind;
    @(negedge clk);
    reqValid = 1'b0;
    chk(memReqValid == expWalk, req, "table walk started", int'(memReqValid), int'(expWalk));
    if (memReqValid) begin
      chk(memAddr == ptBase + 12'(vpn), "R3", "entry address", int'(memAddr), int'(ptBase + 12'(vpn)));
      chk(reqReady == 1'b0, "R3", "ready low while walking", int'(reqReady), 0);
      if (flushMid) begin
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
      end else begin
        @(negedge clk);
      end
      @(negedge clk);
      chk(memReqValid == 1'b1, "R3", "walk held", int'(memReqValid), 1);
      memRspValid = 1'b1; memRspData = pte;
      @(negedge clk);
      memRspValid = 1'b0;
    end
    chk(respValid == 1'b1, req, "response valid", int'(respValid), 1);
    chk(respPageFault == expPf, req, "page fault", int'(respPageFault), int'(expPf));
    chk(respProtFault == expPrf, req, "protection fault", int'(respProtFault), int'(expPrf));
    chk(respPaddr == expPa, req, "physical address", int'(respPaddr), int'(expPa));
    chk(!(respPageFault && respProtFault), "R11", "fault exclusive", int'(respPageFault), 0);
  endtask

  task automatic doFlush();
    @(negedge clk);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
  endtask

  task automatic t_reset();
    chk(reqReady == 1'b1, "R12", "reqReady after reset", int'(reqReady), 1);
    chk(respValid == 1'b0, "R12", "respValid after reset", int'(respValid), 0);
    chk(memReqValid == 1'b0, "R12", "memReqValid after reset", int'(memReqValid), 0);
  endtask

  task automatic t_basic();
    access(14'h03d4, 2'd0, 1, 0, "R3");   // miss, pa 0x354 (R1)
    access(14'h03d4, 2'd0, 0, 0, "R2");   // hit
    access(14'h03d4, 2'd1, 0, 0, "R1");   // write allowed
    access(14'h03d4, 2'd2, 0, 0, "R6");   // fetch denied on a hit
    access(14'h0020, 2'd0, 1, 0, "R4");   // pa 0xa20
    access(14'h036b, 2'd0, 1, 0, "R2");
    access(14'h036b, 2'd0, 0, 0, "R2");   // hit, pa 0xb6b
    access(14'h036b, 2'd1, 0, 0, "R6");   // write denied
  endtask

  task automatic t_pagefault();
    access(14'h038f, 2'd0, 1, 0, "R5");
    access(14'h038f, 2'd0, 1, 0, "R5");   // not stored
  endtask

  task automatic t_exec();
    access(14'h0840, 2'd0, 1, 0, "R7");   // stored despite denial
    access(14'h0840, 2'd2, 0, 0, "R7");   // hit, fetch ok
    access(14'h0840, 2'd3, 0, 0, "R6");   // reserved kind
  endtask

  task automatic t_replace();
    // set 0 holds page 0x00 in way 0
    access(14'h0100, 2'd0, 1, 0, "R8");
    access(14'h0200, 2'd0, 1, 0, "R8");
    access(14'h0300, 2'd0, 1, 0, "R8");
    access(14'h0400, 2'd0, 1, 0, "R8");   // evicts page 0x00
    access(14'h0100, 2'd0, 0, 0, "R8");
    access(14'h0020, 2'd0, 1, 0, "R8");   // evicted, refetch (evicts 0x04)
    access(14'h0200, 2'd0, 0, 0, "R8");
    access(14'h0100, 2'd0, 1, 0, "R8");
  endtask

  task automatic t_flush();
    access(14'h03d4, 2'd0, 0, 0, "R9");
    doFlush();
    access(14'h03d4, 2'd0, 1, 0, "R9");
  endtask

  task automatic t_flushWalk();
    access(14'h0500, 2'd0, 1, 1, "R10");
    access(14'h0500, 2'd0, 1, 0, "R10");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      logic [7:0] iv;
      iv = 8'(i);
      pt[i] = {iv[5:0] ^ 6'h15, 4'b0111};
    end
    pt[8'h0f] = {6'h0d, 4'b0111};
    pt[8'h00] = {6'h28, 4'b0011};
    pt[8'h0d] = {6'h2d, 4'b0011};
    pt[8'h0e] = 10'h000;
    pt[8'h21] = {6'h05, 4'b1001};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_pagefault();
    t_exec();
    t_replace();
    t_flush();
    t_flushWalk();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule